// File: doc/BRIEF.md
# Interruption Entry State Sequencer

This block carries out the fixed series of state-save steps a processor core performs when it takes a trap or interrupt. Once a vector number is accepted, it saves the current status word and writes a forced new one. It hands the front and back entries of the instruction space and offset queues to the saved-queue registers. Then it points fetch at the handler. If the old status word had its state-collection bit set, two extra steps run before the redirect. The first loads the faulting instruction word through a request/valid memory port, but only for a chosen set of vector classes. The second copies seven general registers into shadow slots, one per cycle.

The core presents a synchronous vector request, or a pending external interrupt. The block answers with one write strobe per architectural register group, a general-register read address for the shadow copy, and a one-cycle redirect with a done pulse. All inputs are latched when a request is accepted. Requests that arrive while a sequence is running are not seen.

Top module: `intr_entry_seq`

## Requirements
- R1: After reset every strobe output (status save, status write, queue save, memory request, instruction save, shadow write, redirect, done) is low until a request is accepted.
- R2: In the idle state, `req_i` starts a sequence for `vec_i`. Otherwise, `ext_irq_i` starts a sequence for vector 4, but only when status bit 0 (interrupt enable) is set; with that bit clear it is ignored. `req_i` wins when both are present.
- R3: In the cycle after acceptance, `sav_psw_we_o` carries the old status word, and `psw_we_o` carries a new word that is zero except for bit 28 (wide mode, set by default) and bit 4 (machine-check mask), which is set only for vector 1.
- R4: In that same cycle, `iq_we_o` is high with the front space, front offset, back space and back offset captured at acceptance.
- R5: The instruction capture and the shadow copy happen only when bit 3 of the old status word was set. Otherwise the redirect follows the save cycle directly.
- R6: The shadow copy spans seven consecutive cycles. Slot k (k = 0..6) receives the general register read at address 1, 8, 9, 16, 17, 24, 25 respectively.
- R7: For vectors 12 to 22 and 26 to 28, with bit 3 set, `imem_req_o` is raised after the save cycle at the front offset with its two low bits cleared. It stays high with a stable address until `imem_valid_i`.
- R8: In the cycle in which `imem_valid_i` is high, `iir_we_o` writes `imem_data_i`, or 0 when `imem_fail_i` is high. The shadow copy follows.
- R9: On redirect the new front offset is base + 32 * vector, the back offset is the front plus 4, and both space outputs are zero.
- R10: `done_o` is a single-cycle pulse coincident with `redir_o`, after which the block is idle.
- R11: While a sequence is running, new requests and changes on the context inputs have no effect on any output of that sequence, and they do not start a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Trap/interrupt request |
| vec_i | input | VEC_W | Vector number of the request |
| ext_irq_i | input | 1 | External interrupt pending |
| psw_i | input | XLEN | Current status word |
| iaoq_f_i | input | XLEN | Front instruction offset |
| iaoq_b_i | input | XLEN | Back instruction offset |
| iasq_f_i | input | XLEN | Front space identifier |
| iasq_b_i | input | XLEN | Back space identifier |
| iva_i | input | XLEN | Vector table base |
| gr_data_i | input | XLEN | General register read data |
| imem_valid_i | input | 1 | Instruction fetch response valid |
| imem_fail_i | input | 1 | Fetch address could not be translated |
| imem_data_i | input | XLEN | Fetched instruction word |
| sav_psw_we_o | output | 1 | Saved-status register write |
| sav_psw_o | output | XLEN | Saved-status value |
| psw_we_o | output | 1 | Status word write |
| psw_o | output | XLEN | Forced new status word |
| iq_we_o | output | 1 | Saved-queue registers write |
| sav_sp_f_o | output | XLEN | Saved front space |
| sav_off_f_o | output | XLEN | Saved front offset |
| sav_sp_b_o | output | XLEN | Saved back space |
| sav_off_b_o | output | XLEN | Saved back offset |
| imem_req_o | output | 1 | Instruction fetch request |
| imem_addr_o | output | XLEN | Word-aligned fetch address |
| iir_we_o | output | 1 | Instruction-word register write |
| iir_o | output | XLEN | Captured instruction word |
| gr_addr_o | output | 5 | General register read address |
| shadow_we_o | output | 1 | Shadow slot write |
| shadow_idx_o | output | 3 | Shadow slot index |
| shadow_data_o | output | XLEN | Shadow slot data |
| redir_o | output | 1 | Fetch redirect |
| fetch_off_f_o | output | XLEN | New front offset |
| fetch_off_b_o | output | XLEN | New back offset |
| fetch_sp_f_o | output | XLEN | New front space |
| fetch_sp_b_o | output | XLEN | New back space |
| done_o | output | 1 | Sequence complete pulse |

## Verification
Several properties are checked on every cycle. The fetch address must be word-aligned and must hold while a fetch is outstanding. Shadow slot indices must step by one. A shadow write must never occur unless the latched state-collection bit was set. Done must not last longer than one cycle, and the latched vector must not move while busy. The bench scenarios are needed for the data values: the forced status word for the machine-check vector, the vector address arithmetic including wrap-around, the zero substituted on a failed fetch, the choice between requests and masked external interrupts, and the indifference to traffic that arrives mid-sequence.

// File: rtl/ies_pkg.sv
package ies_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SAVE     = 3'd1,
    ST_CAPTURE  = 3'd2,
    ST_SHADOW   = 3'd3,
    ST_REDIRECT = 3'd4
  } ies_state_e;

  localparam int SHADOW_N = 7;
  localparam int SH_IDX_W = $clog2(SHADOW_N);
  localparam int GR_AW    = 5;

  // Slot k copies general register: 1 for slot 0, then pairs 8/9, 16/17, 24/25
  function automatic logic [GR_AW-1:0] shadow_src(input logic [SH_IDX_W-1:0] k);
    logic [GR_AW-1:0] r;
    logic [GR_AW-1:0] kp1;
    kp1 = GR_AW'(k) + GR_AW'(1);
    if (k == '0) r = GR_AW'(1);
    else         r = {kp1[2:1], 3'b000} | {4'b0000, kp1[0]};
    return r;
  endfunction

endpackage

// File: rtl/ies_ctrl.sv
module ies_ctrl
  import ies_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                q_i,
  input  logic                cap_i,
  input  logic                mem_valid_i,
  output logic                accept_o,
  output ies_state_e          state_o,
  output logic [SH_IDX_W-1:0] sh_idx_o
);

  ies_state_e          state_q, state_d;
  logic [SH_IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    accept_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_SAVE;
        end
      end
      ST_SAVE: begin
        idx_d = '0;
        if (!q_i)      state_d = ST_REDIRECT;
        else if (cap_i) state_d = ST_CAPTURE;
        else           state_d = ST_SHADOW;
      end
      ST_CAPTURE: begin
        if (mem_valid_i) state_d = ST_SHADOW;
      end
      ST_SHADOW: begin
        if (idx_q == SH_IDX_W'(SHADOW_N - 1)) state_d = ST_REDIRECT;
        else                                  idx_d   = idx_q + SH_IDX_W'(1);
      end
      ST_REDIRECT: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o  = state_q;
  assign sh_idx_o = idx_q;

  AST_SHADOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHADOW && idx_q != '0) |->
      ($past(state_q) == ST_SHADOW && $past(idx_q) == idx_q - SH_IDX_W'(1))); // R6

endmodule

// File: rtl/ies_ctx.sv
module ies_ctx #(
  parameter int                    XLEN      = 32,
  parameter int                    VEC_W     = 5,
  parameter int                    Q_BIT     = 3,
  parameter int                    M_BIT     = 4,
  parameter int                    W_BIT     = 28,
  parameter bit                    WIDE      = 1'b1,
  parameter int                    VEC_HPMC  = 1,
  parameter logic [(1<<VEC_W)-1:0] CAP_MASK  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             busy_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [XLEN-1:0]  psw_i,
  input  logic [XLEN-1:0]  off_f_i,
  input  logic [XLEN-1:0]  off_b_i,
  input  logic [XLEN-1:0]  sp_f_i,
  input  logic [XLEN-1:0]  sp_b_i,
  input  logic [XLEN-1:0]  base_i,
  output logic [XLEN-1:0]  psw_q_o,
  output logic [XLEN-1:0]  off_f_q_o,
  output logic [XLEN-1:0]  off_b_q_o,
  output logic [XLEN-1:0]  sp_f_q_o,
  output logic [XLEN-1:0]  sp_b_q_o,
  output logic [XLEN-1:0]  new_psw_o,
  output logic [XLEN-1:0]  tgt_f_o,
  output logic [XLEN-1:0]  tgt_b_o,
  output logic             q_o,
  output logic             cap_o
);

  localparam int VEC_SHIFT = 5;  // 32-byte handler spacing

  logic [VEC_W-1:0] vec_q;
  logic [XLEN-1:0]  base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q     <= '0;
      psw_q_o   <= '0;
      off_f_q_o <= '0;
      off_b_q_o <= '0;
      sp_f_q_o  <= '0;
      sp_b_q_o  <= '0;
      base_q    <= '0;
    end else if (accept_i) begin
      vec_q     <= vec_i;
      psw_q_o   <= psw_i;
      off_f_q_o <= off_f_i;
      off_b_q_o <= off_b_i;
      sp_f_q_o  <= sp_f_i;
      sp_b_q_o  <= sp_b_i;
      base_q    <= base_i;
    end
  end

  always_comb begin
    new_psw_o = '0;
    new_psw_o[W_BIT] = WIDE;
    if (vec_q == VEC_W'(VEC_HPMC)) new_psw_o[M_BIT] = 1'b1;
  end

  assign tgt_f_o = base_q + (XLEN'(vec_q) << VEC_SHIFT);
  assign tgt_b_o = tgt_f_o + XLEN'(4);
  assign q_o     = psw_q_o[Q_BIT];
  assign cap_o   = CAP_MASK[vec_q];

  AST_CTX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(vec_q) && $stable(off_f_q_o) && $stable(base_q))); // R11

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
  import ies_pkg::*;
#(
  parameter int                    XLEN     = 32,
  parameter int                    VEC_W    = 5,
  parameter int                    I_BIT    = 0,
  parameter int                    Q_BIT    = 3,
  parameter int                    M_BIT    = 4,
  parameter int                    W_BIT    = 28,
  parameter bit                    WIDE     = 1'b1,
  parameter int                    VEC_HPMC = 1,
  parameter int                    VEC_EXT  = 4,
  parameter logic [(1<<VEC_W)-1:0] CAP_MASK = 32'h1C7F_F000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic               ext_irq_i,
  input  logic [XLEN-1:0]    psw_i,
  input  logic [XLEN-1:0]    iaoq_f_i,
  input  logic [XLEN-1:0]    iaoq_b_i,
  input  logic [XLEN-1:0]    iasq_f_i,
  input  logic [XLEN-1:0]    iasq_b_i,
  input  logic [XLEN-1:0]    iva_i,
  input  logic [XLEN-1:0]    gr_data_i,
  input  logic               imem_valid_i,
  input  logic               imem_fail_i,
  input  logic [XLEN-1:0]    imem_data_i,
  output logic               sav_psw_we_o,
  output logic [XLEN-1:0]    sav_psw_o,
  output logic               psw_we_o,
  output logic [XLEN-1:0]    psw_o,
  output logic               iq_we_o,
  output logic [XLEN-1:0]    sav_sp_f_o,
  output logic [XLEN-1:0]    sav_off_f_o,
  output logic [XLEN-1:0]    sav_sp_b_o,
  output logic [XLEN-1:0]    sav_off_b_o,
  output logic               imem_req_o,
  output logic [XLEN-1:0]    imem_addr_o,
  output logic               iir_we_o,
  output logic [XLEN-1:0]    iir_o,
  output logic [GR_AW-1:0]   gr_addr_o,
  output logic               shadow_we_o,
  output logic [SH_IDX_W-1:0] shadow_idx_o,
  output logic [XLEN-1:0]    shadow_data_o,
  output logic               redir_o,
  output logic [XLEN-1:0]    fetch_off_f_o,
  output logic [XLEN-1:0]    fetch_off_b_o,
  output logic [XLEN-1:0]    fetch_sp_f_o,
  output logic [XLEN-1:0]    fetch_sp_b_o,
  output logic               done_o
);

  ies_state_e          state;
  logic [SH_IDX_W-1:0] sh_idx;
  logic                accept, q_old, cap_cls, start;
  logic [VEC_W-1:0]    eff_vec;
  logic [XLEN-1:0]     psw_old, off_f_q, off_b_q, sp_f_q, sp_b_q;
  logic [XLEN-1:0]     new_psw, tgt_f, tgt_b;

  // Explicit request outranks a maskable external interrupt
  assign start   = req_i | (ext_irq_i & psw_i[I_BIT]);
  assign eff_vec = req_i ? vec_i : VEC_W'(VEC_EXT);

  ies_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .q_i         (q_old),
    .cap_i       (cap_cls),
    .mem_valid_i (imem_valid_i),
    .accept_o    (accept),
    .state_o     (state),
    .sh_idx_o    (sh_idx)
  );

  ies_ctx #(
    .XLEN     (XLEN),
    .VEC_W    (VEC_W),
    .Q_BIT    (Q_BIT),
    .M_BIT    (M_BIT),
    .W_BIT    (W_BIT),
    .WIDE     (WIDE),
    .VEC_HPMC (VEC_HPMC),
    .CAP_MASK (CAP_MASK)
  ) u_ctx (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .busy_i    (state != ST_IDLE),
    .vec_i     (eff_vec),
    .psw_i     (psw_i),
    .off_f_i   (iaoq_f_i),
    .off_b_i   (iaoq_b_i),
    .sp_f_i    (iasq_f_i),
    .sp_b_i    (iasq_b_i),
    .base_i    (iva_i),
    .psw_q_o   (psw_old),
    .off_f_q_o (off_f_q),
    .off_b_q_o (off_b_q),
    .sp_f_q_o  (sp_f_q),
    .sp_b_q_o  (sp_b_q),
    .new_psw_o (new_psw),
    .tgt_f_o   (tgt_f),
    .tgt_b_o   (tgt_b),
    .q_o       (q_old),
    .cap_o     (cap_cls)
  );

  // Save step
  assign sav_psw_we_o = (state == ST_SAVE);
  assign sav_psw_o    = psw_old;
  assign psw_we_o     = (state == ST_SAVE);
  assign psw_o        = new_psw;
  assign iq_we_o      = (state == ST_SAVE);
  assign sav_sp_f_o   = sp_f_q;
  assign sav_off_f_o  = off_f_q;
  assign sav_sp_b_o   = sp_b_q;
  assign sav_off_b_o  = off_b_q;

  // Instruction capture
  assign imem_req_o  = (state == ST_CAPTURE);
  assign imem_addr_o = {off_f_q[XLEN-1:2], 2'b00};
  assign iir_we_o    = (state == ST_CAPTURE) && imem_valid_i;
  assign iir_o       = imem_fail_i ? '0 : imem_data_i;

  // Shadow copy
  assign gr_addr_o     = shadow_src(sh_idx);
  assign shadow_we_o   = (state == ST_SHADOW);
  assign shadow_idx_o  = sh_idx;
  assign shadow_data_o = gr_data_i;

  // Redirect
  assign redir_o       = (state == ST_REDIRECT);
  assign done_o        = (state == ST_REDIRECT);
  assign fetch_off_f_o = tgt_f;
  assign fetch_off_b_o = tgt_b;
  assign fetch_sp_f_o  = '0;
  assign fetch_sp_b_o  = '0;

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_o |-> (imem_addr_o[1:0] == 2'b00)); // R7

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (imem_req_o && !imem_valid_i) |=> (imem_req_o && $stable(imem_addr_o))); // R7

  AST_SHADOW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_we_o || iir_we_o) |-> sav_psw_o[Q_BIT]); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10

  AST_SAVE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we_o |=> (!psw_we_o && !sav_psw_we_o)); // R3

endmodule

// File: tb/intr_entry_seq_bench.sv
module intr_entry_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, ext_irq_i, imem_valid_i, imem_fail_i;
  logic [4:0]  vec_i;
  logic [31:0] psw_i, iaoq_f_i, iaoq_b_i, iasq_f_i, iasq_b_i, iva_i;
  logic [31:0] gr_data_i, imem_data_i;
  logic        sav_psw_we_o, psw_we_o, iq_we_o, imem_req_o, iir_we_o;
  logic        shadow_we_o, redir_o, done_o;
  logic [31:0] sav_psw_o, psw_o, sav_sp_f_o, sav_off_f_o, sav_sp_b_o, sav_off_b_o;
  logic [31:0] imem_addr_o, iir_o, shadow_data_o;
  logic [31:0] fetch_off_f_o, fetch_off_b_o, fetch_sp_f_o, fetch_sp_b_o;
  logic [4:0]  gr_addr_o;
  logic [2:0]  shadow_idx_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_seq u_intr_entry_seq (.*);

  // Register file and memory stand-ins
  assign gr_data_i   = 32'hC0DE_0000 + 32'(gr_addr_o) * 32'h101;
  assign imem_data_i = imem_addr_o ^ 32'h5A5A_0000;

  typedef struct {
    bit          sv, iq, mreq, iir, sh, rd;
    logic [31:0] v0, v1, v2, v3, v4, v5;
    int          idx;
  } exp_t;

  exp_t  expq[$];
  int    nvec = 0;
  int    nfail = 0;
  string scen = "R1 reset-idle";
  int    lat = 0;
  bit    fail_sel = 1'b0;
  int    mcnt = 0;
  int    regs[7] = '{1, 8, 9, 16, 17, 24, 25};

  // Memory responder: answers after lat waiting cycles
  always @(negedge clk) begin
    if (imem_req_o) begin
      if (mcnt == lat) begin imem_valid_i = 1'b1; mcnt = 0; end
      else begin imem_valid_i = 1'b0; mcnt++; end
    end else begin
      imem_valid_i = 1'b0;
      mcnt = 0;
    end
    imem_fail_i = fail_sel;
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s [%s] act=%h exp=%h @%0t", tag, scen, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_rec();
    exp_t e;
    e = '{sv:0, iq:0, mreq:0, iir:0, sh:0, rd:0,
          v0:'0, v1:'0, v2:'0, v3:'0, v4:'0, v5:'0, idx:0};
    return e;
  endfunction

  // Per-cycle comparison against the model queue, late in the low phase
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      exp_t e;
      e = (expq.size() > 0) ? expq.pop_front() : idle_rec();
      nvec++;
      cmp("R3 sav_psw_we", 32'(sav_psw_we_o), 32'(e.sv));
      cmp("R3 psw_we",     32'(psw_we_o),     32'(e.sv));
      cmp("R4 iq_we",      32'(iq_we_o),      32'(e.iq));
      cmp("R7 imem_req",   32'(imem_req_o),   32'(e.mreq));
      cmp("R8 iir_we",     32'(iir_we_o),     32'(e.iir));
      cmp("R6 shadow_we",  32'(shadow_we_o),  32'(e.sh));
      cmp("R9 redir",      32'(redir_o),      32'(e.rd));
      cmp("R10 done",      32'(done_o),       32'(e.rd));
      if (e.sv) begin
        cmp("R3 saved psw", sav_psw_o, e.v0);
        cmp("R3 new psw",   psw_o,     e.v1);
      end
      if (e.iq) begin
        cmp("R4 sp_f",  sav_sp_f_o,  e.v2);
        cmp("R4 off_f", sav_off_f_o, e.v3);
        cmp("R4 sp_b",  sav_sp_b_o,  e.v4);
        cmp("R4 off_b", sav_off_b_o, e.v5);
      end
      if (e.mreq) cmp("R7 imem_addr", imem_addr_o, e.v0);
      if (e.iir)  cmp("R8 iir", iir_o, e.v1);
      if (e.sh) begin
        cmp("R6 shadow_idx",  32'(shadow_idx_o), 32'(e.idx));
        cmp("R6 shadow_data", shadow_data_o, e.v0);
      end
      if (e.rd) begin
        cmp("R9 off_f", fetch_off_f_o, e.v0);
        cmp("R9 off_b", fetch_off_b_o, e.v1);
        cmp("R9 sp_f",  fetch_sp_f_o,  32'h0);
        cmp("R9 sp_b",  fetch_sp_b_o,  32'h0);
      end
    end
  end

  function automatic bit cap_class(int v);
    return (v >= 12 && v <= 22) || (v >= 26 && v <= 28);
  endfunction

  task automatic run(string s, bit use_req, int vec, bit use_ext,
                     logic [31:0] psw, logic [31:0] f, logic [31:0] b,
                     logic [31:0] spf, logic [31:0] spb, logic [31:0] base,
                     int l, bit fl, bit noise);
    exp_t e;
    int   ev;
    bit   taken;
    @(negedge clk);
    scen = s; lat = l; fail_sel = fl;
    req_i = use_req; vec_i = 5'(vec); ext_irq_i = use_ext;
    psw_i = psw; iaoq_f_i = f; iaoq_b_i = b; iasq_f_i = spf; iasq_b_i = spb; iva_i = base;
    taken = use_req || (use_ext && psw[0]);
    ev = use_req ? vec : 4;
    expq.push_back(idle_rec());
    if (taken) begin
      e = idle_rec(); e.sv = 1; e.iq = 1;
      e.v0 = psw;
      e.v1 = 32'h1000_0000 | ((ev == 1) ? 32'h10 : 32'h0);
      e.v2 = spf; e.v3 = f; e.v4 = spb; e.v5 = b;
      expq.push_back(e);
      if (psw[3]) begin
        if (cap_class(ev)) begin
          for (int i = 0; i <= l; i++) begin
            e = idle_rec(); e.mreq = 1; e.v0 = f & ~32'h3;
            e.iir = (i == l);
            e.v1 = fl ? 32'h0 : ((f & ~32'h3) ^ 32'h5A5A_0000);
            expq.push_back(e);
          end
        end
        for (int k = 0; k < 7; k++) begin
          e = idle_rec(); e.sh = 1; e.idx = k;
          e.v0 = 32'hC0DE_0000 + 32'(regs[k]) * 32'h101;
          expq.push_back(e);
        end
      end
      e = idle_rec(); e.rd = 1;
      e.v0 = base + 32'(ev) * 32;
      e.v1 = base + 32'(ev) * 32 + 32'd4;
      expq.push_back(e);
    end
    @(negedge clk);
    req_i = 1'b0; ext_irq_i = 1'b0;
    if (noise) begin
      // R11: traffic and changed context while the sequence runs
      @(negedge clk);
      req_i = 1'b1; vec_i = 5'd7; ext_irq_i = 1'b1;
      psw_i = 32'hFFFF_FFFF; iaoq_f_i = 32'hDEAD_BEE0; iva_i = 32'h0;
      @(negedge clk);
      @(negedge clk);
      req_i = 1'b0; ext_irq_i = 1'b0;
    end
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nfail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_i = 0; ext_irq_i = 0; vec_i = 0; imem_valid_i = 0; imem_fail_i = 0;
    psw_i = 0; iaoq_f_i = 0; iaoq_b_i = 0; iasq_f_i = 0; iasq_b_i = 0; iva_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: several idle cycles are compared right after reset
    repeat (3) @(negedge clk);
    run("R2 R5 plain trap no collect", 1, 9, 0, 32'h0000_0001, 32'h0000_2000,
        32'h0000_2004, 32'h0000_0011, 32'h0000_0022, 32'h0001_0000, 0, 0, 0);
    run("R7 R8 capture unaligned", 1, 12, 0, 32'h0000_0008, 32'h0000_1003,
        32'h0000_1007, 32'h0000_0033, 32'h0000_0044, 32'h0002_0000, 2, 0, 0);
    run("R8 capture translate fail", 1, 28, 0, 32'h0000_0009, 32'h0000_4440,
        32'h0000_4444, 32'h1, 32'h2, 32'h0003_0000, 0, 1, 0);
    run("R6 shadow without capture", 1, 6, 0, 32'h8000_0008, 32'h0000_5000,
        32'h0000_5004, 32'h5, 32'h6, 32'h0004_0000, 0, 0, 0);
    run("R3 machine check mask", 1, 1, 0, 32'h0000_00FF, 32'h0000_6000,
        32'h0000_6004, 32'h7, 32'h8, 32'h0005_0000, 0, 0, 0);
    run("R2 external enabled", 0, 0, 1, 32'h0000_0001, 32'h0000_7000,
        32'h0000_7004, 32'h9, 32'hA, 32'h0006_0000, 0, 0, 0);
    run("R2 external masked", 0, 0, 1, 32'h0000_0008, 32'h0000_7100,
        32'h0000_7104, 32'h9, 32'hA, 32'h0006_0000, 0, 0, 0);
    run("R2 request beats external", 1, 15, 1, 32'h0000_0009, 32'h0000_8002,
        32'h0000_8006, 32'hB, 32'hC, 32'h0007_0000, 1, 0, 0);
    run("R11 busy ignores traffic", 1, 20, 0, 32'h0000_0008, 32'h0000_9000,
        32'h0000_9004, 32'hD, 32'hE, 32'h0008_0000, 3, 0, 1);
    run("R9 vector 31 wrap", 1, 31, 0, 32'h0000_0000, 32'h0000_A000,
        32'h0000_A004, 32'hF, 32'h10, 32'hFFFF_FF00, 0, 0, 0);
    run("R9 vector 0", 1, 0, 0, 32'h0000_0000, 32'h0000_B000,
        32'h0000_B004, 32'h11, 32'h12, 32'h0009_0000, 0, 0, 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule